// File: doc/BRIEF.md
# Line-Count Driven VSYNC Generator

This block sits next to a video-style capture port that is fed with a transport stream packed into fixed-length lines. It counts accepted bytes into lines of `LINE_BYTES` bytes and counts lines into windows of `WIN_LINES` lines. Its only output towards the capture engine is a synthetic vertical-sync level. That level is high while the last line of a window is being received and low otherwise, so each window produces one rising and one falling edge. The capture engine uses these edges to close its DMA windows.

With the default setting, a line carries two 188-byte packets (376 bytes) and a window is 512 lines. A line-resync input lets the upstream framer restart a line on a packet boundary. A sticky flag reports a window that did not start on the transport sync byte, which means the window boundaries have lost alignment with the packets. An optional single-cycle interrupt marks every change of the sync level.

Top module: `vsync_line_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both counters and forces `vsync`, `irq` and `sync_err` to 0 from the following cycle.
- R2: Accepted bytes (`byte_vld` and `enable` both high) are numbered 0 to LINE_BYTES-1 within a line, and lines are numbered 0 to WIN_LINES-1 within a window. `vsync` rises in the cycle after byte 0 of line WIN_LINES-1 is accepted.
- R3: `vsync` falls in the cycle after byte LINE_BYTES-1 of line WIN_LINES-1 is accepted. The pattern then repeats every LINE_BYTES*WIN_LINES accepted bytes, with `vsync` high for exactly LINE_BYTES-1 accepted bytes of each window.
- R4: A cycle with `byte_vld` low advances no counter and leaves `vsync` unchanged.
- R5: A byte accepted with `line_resync` high becomes byte 0 of a new line. If the line in progress had a nonzero byte count, that line is counted as complete. If the interrupted line was line WIN_LINES-1, `vsync` falls and the resync byte is byte 0 of line 0 of the next window.
- R6: While `enable` is low, bytes are ignored, both counters are held at zero and `vsync` is low from the cycle after `enable` is seen low.
- R7: When `IRQ_ON` is 1, `irq` is high for one cycle, in the same cycle in which `vsync` shows a new level, if `irq_en` was high at the edge that changed `vsync`. Otherwise `irq` stays low.
- R8: If the first byte of a window (byte 0 of line 0) is not SYNC_BYTE (0x47 by default), `sync_err` is set in the following cycle. It then stays set, even through `enable` low, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run control; low clears the counters and the sync level |
| irq_en | input | 1 | Allows the transition interrupt |
| byte_vld | input | 1 | A stream byte is present on `byte_dat` |
| byte_dat | input | 8 | Stream byte |
| line_resync | input | 1 | The byte being accepted starts a new line |
| vsync | output | 1 | Synthetic vertical sync level |
| irq | output | 1 | One-cycle pulse on each change of `vsync` |
| sync_err | output | 1 | Sticky flag for a window that did not start on the sync byte |

## Verification
Every result of this block is due exactly one clock after the edge that accepts the byte or control value causing it. The rise, the fall, the interrupt pulse, the error flag and the clearing by `enable` all follow this rule, since each goes through one register. The bench drives inputs just after a falling edge and updates its own model of the byte and line position with those inputs. It then compares all three outputs with that model at the next falling edge, which lies half a period after the rising edge that updated them. This covers gaps in `byte_vld`, resyncs and disables, because the model advances only on the bytes the requirements say are accepted.

// File: rtl/vsg_pkg.sv
package vsg_pkg;

   // Events produced by the byte position counter for one accepted byte.
   typedef struct packed {
      logic first;   // byte begins a line
      logic last;    // byte completes a line at full length
      logic cut;     // a partial line was ended by a resync on this byte
   } byte_evt_t;

endpackage

// File: rtl/vsg_byte_pos.sv
module vsg_byte_pos
   import vsg_pkg::*;
#(
   parameter int LINE_BYTES = 376
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      clr,
   input  logic      take,
   input  logic      resync,
   output byte_evt_t evt,
   output logic      busy_nxt
);

   localparam int PW = (LINE_BYTES > 2) ? $clog2(LINE_BYTES) : 1;
   localparam logic [PW-1:0] POS_LAST = PW'(LINE_BYTES - 1);
   localparam logic [PW-1:0] POS_ONE  = PW'(1);

   logic [PW-1:0] pos_q;
   logic [PW-1:0] pos_d;
   logic          at_zero;
   logic          at_last;

   assign at_zero = (pos_q == '0);
   assign at_last = (pos_q == POS_LAST);

   always_comb begin
      evt.first = take & (resync | at_zero);
      evt.cut   = take & resync & ~at_zero;
      evt.last  = take & ~resync & at_last;
   end

   always_comb begin
      pos_d = pos_q;
      if (clr) begin
         pos_d = '0;
      end else if (take) begin
         if (resync)       pos_d = POS_ONE;
         else if (at_last) pos_d = '0;
         else              pos_d = pos_q + POS_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) pos_q <= '0;
      else     pos_q <= pos_d;
   end

   assign busy_nxt = (pos_d != '0);

endmodule

// File: rtl/vsg_line_idx.sv
module vsg_line_idx
   import vsg_pkg::*;
#(
   parameter int WIN_LINES = 512
) (
   input  logic      clk,
   input  logic      rst,
   input  logic      clr,
   input  byte_evt_t evt,
   output logic      win_first,
   output logic      final_nxt
);

   localparam int LW = (WIN_LINES > 2) ? $clog2(WIN_LINES) : 1;
   localparam logic [LW-1:0] LINE_LAST = LW'(WIN_LINES - 1);
   localparam logic [LW-1:0] LINE_ONE  = LW'(1);

   logic [LW-1:0] line_q;
   logic [LW-1:0] line_d;
   logic [LW-1:0] line_inc;
   logic [LW-1:0] line_of_byte;
   logic          step;

   assign step         = evt.cut | evt.last;
   assign line_inc     = (line_q == LINE_LAST) ? '0 : (line_q + LINE_ONE);
   assign line_of_byte = evt.cut ? line_inc : line_q;
   assign win_first    = evt.first & (line_of_byte == '0);

   always_comb begin
      line_d = line_q;
      if (clr)       line_d = '0;
      else if (step) line_d = line_inc;
   end

   always_ff @(posedge clk) begin
      if (rst) line_q <= '0;
      else     line_q <= line_d;
   end

   assign final_nxt = (line_d == LINE_LAST);

endmodule

// File: rtl/vsg_edge_out.sv
module vsg_edge_out #(
   parameter bit IRQ_ON = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic level_d,
   input  logic irq_en,
   output logic vsync,
   output logic irq
);

   logic vs_q;

   always_ff @(posedge clk) begin
      if (rst) vs_q <= 1'b0;
      else     vs_q <= level_d;
   end

   assign vsync = vs_q;

   generate
      if (IRQ_ON) begin : g_irq
         logic irq_q;
         always_ff @(posedge clk) begin
            if (rst) irq_q <= 1'b0;
            else     irq_q <= irq_en & (level_d ^ vs_q);
         end
         assign irq = irq_q;
      end else begin : g_no_irq
         logic unused_irq_en;
         assign unused_irq_en = irq_en;
         assign irq = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/vsg_sync_chk.sv
module vsg_sync_chk #(
   parameter logic [7:0] SYNC_BYTE = 8'h47
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       win_first,
   input  logic [7:0] dat,
   output logic       err
);

   logic err_q;

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= err_q | (win_first & (dat != SYNC_BYTE));
   end

   assign err = err_q;

endmodule

// File: rtl/vsync_line_gen.sv
module vsync_line_gen
   import vsg_pkg::*;
#(
   parameter int         LINE_BYTES = 376,
   parameter int         WIN_LINES  = 512,
   parameter logic [7:0] SYNC_BYTE  = 8'h47,
   parameter bit         IRQ_ON     = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       enable,
   input  logic       irq_en,
   input  logic       byte_vld,
   input  logic [7:0] byte_dat,
   input  logic       line_resync,
   output logic       vsync,
   output logic       irq,
   output logic       sync_err
);

   generate
      if (LINE_BYTES < 2) begin : g_bad_line
         $error("vsync_line_gen: LINE_BYTES must be at least 2");
      end
      if (WIN_LINES < 2) begin : g_bad_win
         $error("vsync_line_gen: WIN_LINES must be at least 2");
      end
   endgenerate

   logic      take;
   logic      clr;
   byte_evt_t evt;
   logic      busy_nxt;
   logic      win_first;
   logic      final_nxt;
   logic      level_d;

   assign take = byte_vld & enable;
   assign clr  = ~enable;

   vsg_byte_pos #(.LINE_BYTES(LINE_BYTES)) u_pos (
      .clk      (clk),
      .rst      (rst),
      .clr      (clr),
      .take     (take),
      .resync   (line_resync),
      .evt      (evt),
      .busy_nxt (busy_nxt)
   );

   vsg_line_idx #(.WIN_LINES(WIN_LINES)) u_line (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr),
      .evt       (evt),
      .win_first (win_first),
      .final_nxt (final_nxt)
   );

   assign level_d = enable & busy_nxt & final_nxt;

   vsg_edge_out #(.IRQ_ON(IRQ_ON)) u_out (
      .clk     (clk),
      .rst     (rst),
      .level_d (level_d),
      .irq_en  (irq_en),
      .vsync   (vsync),
      .irq     (irq)
   );

   vsg_sync_chk #(.SYNC_BYTE(SYNC_BYTE)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .win_first (win_first),
      .dat       (byte_dat),
      .err       (sync_err)
   );

endmodule

// File: rtl/vsync_line_gen_chk.sv
module vsync_line_gen_chk #(
   parameter int LINE_BYTES = 376
) (
   input logic clk,
   input logic rst,
   input logic enable,
   input logic irq_en,
   input logic byte_vld,
   input logic vsync,
   input logic irq,
   input logic sync_err
);

   localparam int CW = $clog2(LINE_BYTES) + 1;

   logic [1:0]    age;
   logic          warm;
   logic [CW-1:0] hi_bytes;

   always_ff @(posedge clk) begin
      if (rst)              age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end
   assign warm = (age != 2'd0);

   // accepted bytes seen while the sync level is high
   always_ff @(posedge clk) begin
      if (rst || !vsync)              hi_bytes <= '0;
      else if (byte_vld && enable)    hi_bytes <= hi_bytes + CW'(1);
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!vsync && !irq && !sync_err));

   assert_high_span_R3: assert property (@(posedge clk) disable iff (rst)
      hi_bytes <= CW'(LINE_BYTES - 1));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (warm && enable && !byte_vld) |=> $stable(vsync));

   assert_off_low_R6: assert property (@(posedge clk) disable iff (rst)
      !enable |=> !vsync);

   assert_irq_on_edge_R7: assert property (@(posedge clk) disable iff (rst)
      (warm && irq) |-> (vsync != $past(vsync)));

   assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
      !irq_en |=> !irq);

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      sync_err |=> sync_err);

endmodule

bind vsync_line_gen vsync_line_gen_chk #(.LINE_BYTES(LINE_BYTES)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .enable   (enable),
   .irq_en   (irq_en),
   .byte_vld (byte_vld),
   .vsync    (vsync),
   .irq      (irq),
   .sync_err (sync_err)
);

// File: tb/sim_vsync_line_gen.sv
module sim_vsync_line_gen;

   localparam int L = 6;
   localparam int W = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       enable = 1'b0;
   logic       irq_en = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_dat = 8'h00;
   logic       line_resync = 1'b0;
   logic       vsync;
   logic       irq;
   logic       sync_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   // bench model of position and expected outputs
   int m_pos  = 0;
   int m_line = 0;
   bit m_vs   = 1'b0;
   bit m_irq  = 1'b0;
   bit m_err  = 1'b0;

   always #10 clk = ~clk;

   vsync_line_gen #(.LINE_BYTES(L), .WIN_LINES(W), .SYNC_BYTE(8'h47), .IRQ_ON(1'b1)) u0 (
      .clk(clk), .rst(rst), .enable(enable), .irq_en(irq_en),
      .byte_vld(byte_vld), .byte_dat(byte_dat), .line_resync(line_resync),
      .vsync(vsync), .irq(irq), .sync_err(sync_err)
   );

   function automatic int next_line(int ln);
      return (ln == W - 1) ? 0 : ln + 1;
   endfunction

   // true when the next accepted byte opens a window
   function automatic bit opens_window(bit rs);
      int ln;
      ln = (rs && m_pos != 0) ? next_line(m_line) : m_line;
      return (rs || m_pos == 0) && (ln == 0);
   endfunction

   function automatic void model_step(bit r, bit en, bit ie, bit v, bit rs, logic [7:0] d);
      bit nvs;
      if (r) begin
         m_pos = 0; m_line = 0; m_vs = 0; m_irq = 0; m_err = 0;
         return;
      end
      if (!en) begin
         m_pos = 0; m_line = 0;
      end else if (v) begin
         if (opens_window(rs) && d != 8'h47) m_err = 1'b1;
         if (rs) begin
            if (m_pos != 0) m_line = next_line(m_line);
            m_pos = 1;
         end else if (m_pos == L - 1) begin
            m_pos = 0;
            m_line = next_line(m_line);
         end else begin
            m_pos = m_pos + 1;
         end
      end
      nvs = en && (m_line == W - 1) && (m_pos != 0);
      m_irq = ie && (nvs != m_vs);
      m_vs = nvs;
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   // one cycle: drive after a falling edge, compare at the next falling edge
   task automatic cyc(string req, bit r, bit en, bit ie, bit v, bit rs, logic [7:0] d);
      rst = r; enable = en; irq_en = ie; byte_vld = v; line_resync = rs; byte_dat = d;
      model_step(r, en, ie, v, rs, d);
      @(posedge clk);
      @(negedge clk);
      chk(req, "vsync", vsync, m_vs);
      chk(req, "irq", irq, m_irq);
      chk(req, "sync_err", sync_err, m_err);
   endtask

   // one accepted byte with a correct sync byte at window starts
   task automatic good_byte(string req, bit ie, bit rs);
      logic [7:0] d;
      d = opens_window(rs) ? 8'h47 : 8'($urandom_range(0, 255));
      cyc(req, 1'b0, 1'b1, ie, 1'b1, rs, d);
   endtask

   initial begin
      void'($urandom(32'd1357));
      @(negedge clk);
      for (int i = 0; i < 3; i++) cyc("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      // R1: reset state right after release
      cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);

      // R2: continuous stream, first rise on the last line
      for (int i = 0; i < L * W; i++) good_byte("R2", 1'b1, 1'b0);
      // R3: further windows, fall and repeat
      for (int i = 0; i < 2 * L * W; i++) good_byte("R3", 1'b1, 1'b0);

      // R4: random gaps between bytes
      for (int i = 0; i < 300; i++) begin
         if ($urandom_range(0, 2) == 0) good_byte("R4", 1'b1, 1'b0);
         else cyc("R4", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
      end

      // R5: resync in a middle line, then inside the last line
      while (!(m_line == 1 && m_pos == 3)) good_byte("R5", 1'b1, 1'b0);
      good_byte("R5", 1'b1, 1'b1);
      while (!(m_line == W - 1 && m_pos == 2)) good_byte("R5", 1'b1, 1'b0);
      good_byte("R5", 1'b1, 1'b1);
      good_byte("R5", 1'b1, 1'b1);   // resync at position 1
      for (int i = 0; i < L * W; i++) good_byte("R5", 1'b1, 1'b0);

      // R6: disable inside the last line, bytes ignored while off
      while (!(m_line == W - 1 && m_pos == 3)) good_byte("R6", 1'b1, 1'b0);
      for (int i = 0; i < 8; i++) cyc("R6", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h11);
      for (int i = 0; i < L * W + 3; i++) good_byte("R6", 1'b1, 1'b0);

      // R7: interrupt enable toggled at random
      for (int i = 0; i < 400; i++) good_byte("R7", 1'($urandom_range(0, 1)), 1'b0);

      // R8: bad window start, sticky through disable, cleared by reset
      while (!(m_line == 0 && m_pos == 0)) good_byte("R8", 1'b1, 1'b0);
      cyc("R8", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h48);
      for (int i = 0; i < 10; i++) good_byte("R8", 1'b1, 1'b0);
      for (int i = 0; i < 3; i++) cyc("R8", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
      cyc("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      cyc("R8", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00);

      // mixed random run over all controls
      for (int i = 0; i < 3000; i++) begin
         bit en, v, rs, ie;
         logic [7:0] d;
         en = ($urandom_range(0, 99) != 0);
         v  = ($urandom_range(0, 3) != 0);
         rs = ($urandom_range(0, 19) == 0);
         ie = ($urandom_range(0, 4) != 0);
         d  = (opens_window(rs) && $urandom_range(0, 29) != 0) ? 8'h47 : 8'($urandom_range(0, 255));
         cyc("R5", 1'b0, en, ie, v, rs, d);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule